// File: doc/BRIEF.md
# Per-Stage Clock-Gated Two-Stage Data RAM

This block wraps a data RAM whose access runs through two pipeline stages and supplies each stage with its own clock enable. Stage 1 takes the request and performs writes. Stage 2 captures read data. Each enable goes through a latch that is transparent while the clock is low, and then through an AND gate. The result is a glitch-free gated clock for each stage. In the default fine mode, a stage's clock runs only in cycles where that stage holds live work. Idle cycles are therefore suppressed even in sparse or bursty traffic. A write-only request never clocks stage 2.

A configuration input selects a coarse mode. In this mode one shared enable drives both stages. A small state machine tracks idle cycles with three states: `GS_BUSY`, `GS_IDLE_ONE` and `GS_GATED`. Its transitions are:
- `GS_BUSY` goes to `GS_IDLE_ONE` on a cycle with no request.
- `GS_IDLE_ONE` goes to `GS_GATED` on a second idle cycle.
- `GS_GATED` stays in `GS_GATED` while no request arrives.
- Any state goes to `GS_BUSY` when a request is present.

Reset places the machine in `GS_GATED`. In coarse mode the clock runs whenever a request is present or the state is not `GS_GATED`.

Read data and its valid flag arrive two cycles after the request in either mode. A request in cycle t gives output valid after the clock edge that ends cycle t+1. Per-stage counters of enabled cycles let a bench measure how many cycles were suppressed.

Top module: `ram_stage_gate`

## Requirements
- R1: In fine mode (`coarse_mode`=0), `s1_clk_en` equals `req_vld` in the same cycle.
- R2: In fine mode, `s2_clk_en` is high exactly in the cycle after a read request (`req_vld`=1, `req_we`=0). It is low after a write-only request or after an idle cycle.
- R3: In coarse mode (`coarse_mode`=1), `s1_clk_en` and `s2_clk_en` are equal. They are high when `req_vld` is high now or was high in either of the two previous cycles, and low otherwise. After reset, with no request, they are low.
- R4: `rd_vld` rises after the second rising edge following a read request, for exactly one cycle per read, in both modes. `rd_data` then holds the word stored at the requested address. Write requests never raise `rd_vld`.
- R5: A write (`req_we`=1) takes effect in stage 1. A read of the same address in the very next cycle returns the new data.
- R6: `s1_en_cnt` and `s2_en_cnt` each increase by one at every rising edge at which the matching enable was high. A 16-cycle window in fine mode with 5 idle cycles therefore adds 11 to `s1_en_cnt`.
- R7: `s1_gclk` and `s2_gclk` give one rising edge per enabled cycle and none in suppressed cycles.
- R8: While `rst_n` is low, `rd_vld` is 0 and both counters are 0. With `req_vld` low, both enables are 0.
- R9: `rd_data` does not change across a rising edge at which `s2_clk_en` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coarse_mode | input | 1 | 1 selects shared enable with two-idle-cycle hold-off |
| req_vld | input | 1 | Access request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| s1_clk_en | output | 1 | Stage 1 clock enable (pre-latch) |
| s2_clk_en | output | 1 | Stage 2 clock enable (pre-latch) |
| s1_gclk | output | 1 | Gated clock for stage 1 |
| s2_gclk | output | 1 | Gated clock for stage 2 |
| s1_en_cnt | output | CNT_W | Count of stage 1 enabled cycles |
| s2_en_cnt | output | CNT_W | Count of stage 2 enabled cycles |

## Verification
The hardest condition to reach is the coarse machine's exact hold-off boundary. A request must land precisely in the first, second or third idle cycle after activity, because that is the only place where coarse and fine enables differ. The bench drives coarse-mode traffic with idle gaps of one, two and three cycles, plus a request that arrives while the machine is `GS_GATED`. It compares every cycle's enables against a cycle-level model of the idle run. The same model also tracks write-then-read ordering and the two-cycle read latency in both modes.

// File: rtl/ramcg_pkg.sv
package ramcg_pkg;

    typedef enum logic [1:0] {
        GS_BUSY     = 2'd0,
        GS_IDLE_ONE = 2'd1,
        GS_GATED    = 2'd2
    } gate_state_e;

    localparam int NUM_STAGES = 2;

endpackage

// File: rtl/ramcg_stage_track.sv
module ramcg_stage_track (
    input  logic clk,
    input  logic rst_n,
    input  logic req_vld,
    input  logic req_we,
    output logic s1_rd_live,
    output logic rd_vld
);

    // Valid tracking runs on the free clock so it can empty while data stages sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_rd_live <= 1'b0;
            rd_vld     <= 1'b0;
        end else begin
            s1_rd_live <= req_vld && !req_we;
            rd_vld     <= s1_rd_live;
        end
    end

endmodule

// File: rtl/ramcg_gate_ctrl.sv
module ramcg_gate_ctrl
    import ramcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic coarse_mode,
    input  logic req_vld,
    input  logic s1_rd_live,
    output logic s1_en,
    output logic s2_en
);

    gate_state_e state_q, state_d;
    logic        coarse_en;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_GATED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_BUSY:     state_d = req_vld ? GS_BUSY : GS_IDLE_ONE;
            GS_IDLE_ONE: state_d = req_vld ? GS_BUSY : GS_GATED;
            GS_GATED:    state_d = req_vld ? GS_BUSY : GS_GATED;
            default:     state_d = GS_GATED;
        endcase
    end

    always_comb begin
        coarse_en = req_vld || (state_q != GS_GATED);
        if (coarse_mode) begin
            s1_en = coarse_en;
            s2_en = coarse_en;
        end else begin
            s1_en = req_vld;
            s2_en = s1_rd_live;
        end
    end

endmodule

// File: rtl/ramcg_clk_gate.sv
module ramcg_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);

    logic en_lat;

    // Transparent while clk is low; held while high, so gclk cannot glitch.
    always_latch begin
        if (!clk) en_lat = en;
    end

    assign gclk = clk & en_lat;

endmodule

// File: rtl/ramcg_en_counter.sv
module ramcg_en_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n)  cnt <= '0;
        else if (en) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ramcg_ram_model.sv
module ramcg_ram_model #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              s1_en,
    input  logic              s2_en,
    input  logic              req_vld,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] s1_addr;

    // Stage 1: address capture and write, clocked only when enabled.
    always_ff @(posedge clk) begin
        if (s1_en) begin
            s1_addr <= req_addr;
            if (req_vld && req_we) mem[req_addr] <= req_wdata;
        end
    end

    // Stage 2: array read into the output register.
    always_ff @(posedge clk) begin
        if (s2_en) rd_data <= mem[s1_addr];
    end

endmodule

// File: rtl/ram_stage_gate.sv
module ram_stage_gate
    import ramcg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coarse_mode,
    input  logic              req_vld,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_data,
    output logic              s1_clk_en,
    output logic              s2_clk_en,
    output logic              s1_gclk,
    output logic              s2_gclk,
    output logic [CNT_W-1:0]  s1_en_cnt,
    output logic [CNT_W-1:0]  s2_en_cnt
);

    logic                  s1_rd_live;
    logic [NUM_STAGES-1:0] stage_en;
    logic [NUM_STAGES-1:0] stage_gclk;
    logic [CNT_W-1:0]      stage_cnt [NUM_STAGES];

    ramcg_stage_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_vld    (req_vld),
        .req_we     (req_we),
        .s1_rd_live (s1_rd_live),
        .rd_vld     (rd_vld)
    );

    ramcg_gate_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .coarse_mode (coarse_mode),
        .req_vld     (req_vld),
        .s1_rd_live  (s1_rd_live),
        .s1_en       (stage_en[0]),
        .s2_en       (stage_en[1])
    );

    ramcg_ram_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk       (clk),
        .s1_en     (stage_en[0]),
        .s2_en     (stage_en[1]),
        .req_vld   (req_vld),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data)
    );

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        ramcg_clk_gate u_cg (
            .clk  (clk),
            .en   (stage_en[g]),
            .gclk (stage_gclk[g])
        );
        ramcg_en_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (stage_en[g]),
            .cnt   (stage_cnt[g])
        );
    end

    assign s1_clk_en = stage_en[0];
    assign s2_clk_en = stage_en[1];
    assign s1_gclk   = stage_gclk[0];
    assign s2_gclk   = stage_gclk[1];
    assign s1_en_cnt = stage_cnt[0];
    assign s2_en_cnt = stage_cnt[1];

endmodule

// File: rtl/ramcg_checker.sv
module ramcg_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              coarse_mode,
    input logic              req_vld,
    input logic              req_we,
    input logic              rd_vld,
    input logic [DATA_W-1:0] rd_data,
    input logic              s1_clk_en,
    input logic              s2_clk_en,
    input logic [CNT_W-1:0]  s1_en_cnt,
    input logic [CNT_W-1:0]  s2_en_cnt
);

    AST_FINE_S1_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !coarse_mode |-> (s1_clk_en == req_vld)); // R1

    AST_FINE_S2_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!coarse_mode && !$past(coarse_mode)) |-> (s2_clk_en == $past(req_vld && !req_we))); // R2

    AST_COARSE_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_mode |-> (s1_clk_en == s2_clk_en)); // R3

    AST_COARSE_HOLD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_mode && $past(coarse_mode) && $past(req_vld)) |-> s1_clk_en); // R3

    AST_COARSE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_mode && !req_vld && !$past(req_vld) && !$past(req_vld, 2)) |-> !s1_clk_en); // R3

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld == $past(req_vld && !req_we, 2)); // R4

    AST_CNT1_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        s1_en_cnt == $past(s1_en_cnt) + CNT_W'($past(s1_clk_en))); // R6

    AST_CNT2_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        s2_en_cnt == $past(s2_en_cnt) + CNT_W'($past(s2_clk_en))); // R6

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!s2_clk_en) |-> $stable(rd_data)); // R9

endmodule

bind ram_stage_gate ramcg_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .coarse_mode (coarse_mode),
    .req_vld     (req_vld),
    .req_we      (req_we),
    .rd_vld      (rd_vld),
    .rd_data     (rd_data),
    .s1_clk_en   (s1_clk_en),
    .s2_clk_en   (s2_clk_en),
    .s1_en_cnt   (s1_en_cnt),
    .s2_en_cnt   (s2_en_cnt)
);

// File: tb/tb_ram_stage_gate.sv
module tb_ram_stage_gate;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              coarse_mode = 1'b0;
    logic              req_vld = 1'b0;
    logic              req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rd_vld;
    logic [DATA_W-1:0] rd_data;
    logic              s1_clk_en, s2_clk_en, s1_gclk, s2_gclk;
    logic [CNT_W-1:0]  s1_en_cnt, s2_en_cnt;

    ram_stage_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .coarse_mode(coarse_mode),
        .req_vld(req_vld), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_vld(rd_vld), .rd_data(rd_data),
        .s1_clk_en(s1_clk_en), .s2_clk_en(s2_clk_en),
        .s1_gclk(s1_gclk), .s2_gclk(s2_gclk),
        .s1_en_cnt(s1_en_cnt), .s2_en_cnt(s2_en_cnt)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model state
    logic [DATA_W-1:0] exp_mem [1 << ADDR_W];
    logic              prev_rd = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic              exp_rd_vld = 1'b0;
    logic [DATA_W-1:0] exp_rd_data = '0;
    int                idle_run = 2;
    int                cnt1 = 0, cnt2 = 0;
    int                g1 = 0, g2 = 0;
    logic              count_on = 1'b0;

    always @(posedge s1_gclk) if (count_on) g1++;
    always @(posedge s2_gclk) if (count_on) g2++;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle of stimulus with full per-cycle checking; entered and left just after a negedge.
    task automatic drive(input logic v, input logic we, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d);
        logic e1, e2;
        logic [DATA_W-1:0] rd_before;
        req_vld = v; req_we = we; req_addr = a; req_wdata = d;
        #1;
        e1 = coarse_mode ? (v || idle_run < 2) : v;
        e2 = coarse_mode ? e1 : prev_rd;
        chk(coarse_mode ? "R3 s1 enable" : "R1 s1 enable", 64'(s1_clk_en), 64'(e1));
        chk(coarse_mode ? "R3 s2 enable" : "R2 s2 enable", 64'(s2_clk_en), 64'(e2));
        rd_before = rd_data;
        @(posedge clk);
        if (e1) cnt1++;
        if (e2) cnt2++;
        exp_rd_vld = prev_rd;
        if (prev_rd) exp_rd_data = exp_mem[prev_addr];
        if (v && we) exp_mem[a] = d;
        prev_rd   = v && !we;
        prev_addr = a;
        idle_run  = v ? 0 : ((idle_run < 2) ? idle_run + 1 : 2);
        @(negedge clk);
        chk("R4 rd_vld", 64'(rd_vld), 64'(exp_rd_vld));
        if (exp_rd_vld) chk("R4 rd_data", 64'(rd_data), 64'(exp_rd_data));
        if (!e2) chk("R9 rd_data hold", 64'(rd_data), 64'(rd_before));
        chk("R6 s1 count", 64'(s1_en_cnt), 64'(cnt1));
        chk("R6 s2 count", 64'(s2_en_cnt), 64'(cnt2));
        chk("R7 s1 gated edges", 64'(g1), 64'(cnt1));
        chk("R7 s2 gated edges", 64'(g2), 64'(cnt2));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, '0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 rd_vld in reset", 64'(rd_vld), 64'h0);
        chk("R8 s1 count in reset", 64'(s1_en_cnt), 64'h0);
        chk("R8 s2 count in reset", 64'(s2_en_cnt), 64'h0);
        chk("R8 s1 enable in reset", 64'(s1_clk_en), 64'h0);
        chk("R8 s2 enable in reset", 64'(s2_clk_en), 64'h0);
        rst_n = 1'b1;
        count_on = 1'b1;
        // Coarse machine starts gated: no enable without a request.
        coarse_mode = 1'b1;
        idle(2);
        coarse_mode = 1'b0;
    endtask

    task automatic t_fill();
        for (int i = 0; i < 16; i++) drive(1'b1, 1'b1, ADDR_W'(i), 32'hA500_0000 + i);
        idle(2);
    endtask

    task automatic t_fine_back_to_back();
        for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, ADDR_W'(i), '0);
        idle(3);
    endtask

    task automatic t_fine_sparse();
        drive(1'b1, 1'b0, 6'd3, '0);
        idle(1);
        drive(1'b1, 1'b0, 6'd9, '0);
        idle(2);
        drive(1'b1, 1'b0, 6'd12, '0);
        idle(3);
    endtask

    task automatic t_write_only();
        int c2;
        c2 = cnt2;
        drive(1'b1, 1'b1, 6'd20, 32'h1234_5678);
        drive(1'b1, 1'b1, 6'd21, 32'h8765_4321);
        idle(2);
        chk("R2 write-only leaves stage 2 off", 64'(s2_en_cnt), 64'(c2));
        chk("R4 no rd_vld after writes", 64'(rd_vld), 64'h0);
    endtask

    task automatic t_write_then_read();
        drive(1'b1, 1'b1, 6'd33, 32'hCAFE_F00D);
        drive(1'b1, 1'b0, 6'd33, '0);
        drive(1'b0, 1'b0, '0, '0);
        chk("R5 read sees prior write", 64'(rd_data), 64'hCAFE_F00D);
        chk("R5 rd_vld for that read", 64'(rd_vld), 64'h1);
        idle(2);
    endtask

    task automatic t_coarse();
        coarse_mode = 1'b1;
        drive(1'b1, 1'b0, 6'd1, '0);
        idle(1);
        drive(1'b1, 1'b0, 6'd2, '0);
        idle(2);
        drive(1'b1, 1'b1, 6'd40, 32'h0BAD_BEEF);
        idle(3);
        chk("R3 suspended after two idle cycles", 64'(s1_clk_en), 64'h0);
        drive(1'b1, 1'b0, 6'd40, '0);
        drive(1'b0, 1'b0, '0, '0);
        chk("R4 coarse read latency", 64'(rd_data), 64'h0BAD_BEEF);
        idle(3);
        coarse_mode = 1'b0;
        idle(1);
    endtask

    task automatic t_pattern16();
        int base1;
        logic [15:0] pat;
        pat = 16'b1101_1011_0110_1101;
        base1 = int'(s1_en_cnt);
        for (int i = 0; i < 16; i++) drive(pat[i], 1'b0, ADDR_W'(i), '0);
        chk("R6 eleven enabled of sixteen", 64'(int'(s1_en_cnt) - base1), 64'd11);
        idle(2);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fill();
        t_fine_back_to_back();
        t_fine_sparse();
        t_write_only();
        t_write_then_read();
        t_coarse();
        t_pattern16();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule